// File: doc/BRIEF.md
# ADC Convert-and-Readout Sequencer

This block runs a complete sample cycle for a successive-approximation converter that has a serial output. A one-cycle timer tick starts the cycle. The block drives an active-low convert-start pulse of fixed length. It then follows the converter's busy line: first it waits for busy to go high, then for busy to go low again. After that it pulls chip select low and clocks out a 32-bit result as two 16-bit words. The serial clock idles low, and the block samples data on the falling clock transition. The block presents the result as a single 32-bit value with a one-cycle valid strobe.

A tick that arrives while a cycle is still running is discarded, and a sticky overrun flag records the loss. The serial clock is the system clock divided by twice a parameter. The design bounds that divider so the serial clock never exceeds 17 MHz.

The state machine has these states:
- ST_IDLE: waits for a tick. A tick moves it to ST_CONV.
- ST_CONV: holds convert-start low for CNV_LEN clocks, then moves to ST_WAIT_HI.
- ST_WAIT_HI: moves to ST_WAIT_LO when busy is high.
- ST_WAIT_LO: moves to ST_XFER when busy is low.
- ST_XFER: holds chip select low. After the 32nd falling clock transition it moves to ST_GAP.
- ST_GAP: holds chip select high for 2*SCLK_DIV clocks, then moves to ST_DONE.
- ST_DONE: raises valid for one cycle, then returns to ST_IDLE.

Top module: `adc_rd_ctrl`

## Requirements
- R1: A tick sampled in ST_IDLE drives cnv_n_o low on the next clock edge. cnv_n_o then stays low for exactly CNV_LEN clocks (default 3).
- R2: cs_n_o goes low only after busy_i has been high and then low following the convert pulse. cs_n_o is never low while busy_i is high.
- R3: One readout produces exactly 32 rising serial-clock edges while cs_n_o is held low without a break. Bits arrive MSB first. The first 16-bit word forms result_o[31:16] and the second forms result_o[15:0].
- R4: sclk_o is low whenever cs_n_o is high. Each sclk_o level lasts SCLK_DIV clocks (default 2). Each half period is at least ceil(CLK_HZ / (2*17 MHz)) clocks. miso_i is sampled on the clock edge where sclk_o falls.
- R5: cs_n_o rises on the edge of the last falling serial transition. valid_o rises exactly 2*SCLK_DIV clocks later, lasts one cycle, and is only high while cs_n_o is high.
- R6: A tick that arrives in any state other than ST_IDLE starts nothing. It sets overrun_o on the next edge. overrun_o stays set until ovr_clr_i is sampled high with no tick in the same cycle.
- R7: A second convert pulse is issued only after busy_i has fallen since the previous pulse.
- R8: While reset is asserted, cnv_n_o and cs_n_o are high, and sclk_o, valid_o and overrun_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle timer event that requests a conversion |
| busy_i | input | 1 | Converter busy line, high during a conversion |
| miso_i | input | 1 | Serial data from the converter |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| cnv_n_o | output | 1 | Active-low convert-start pulse |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles low |
| result_o | output | 32 | Assembled result, first word in the upper half |
| valid_o | output | 1 | One-cycle strobe: result_o holds a fresh sample |
| overrun_o | output | 1 | Sticky flag: a tick was dropped |

## Verification
The assertions cover properties that hold on every cycle:
- the clock idles low whenever chip select is high,
- the minimum half-period of the serial clock,
- no chip-select low while busy is high,
- the convert pulse length and its re-arm after busy falls,
- the single-cycle, chip-select-high valid strobe,
- overrun rising only after a tick.

The bench scenarios show what the assertions cannot. These are the assembled word value and bit order, using walking-one and walking-zero patterns over all 32 positions. They also include the exact count of 32 clock edges, the precise gap between chip select and valid, and that a tick dropped during readout leaves the frame intact.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_XFER,
        ST_GAP,
        ST_DONE
    } rd_state_t;
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sclk_o,
    output logic fall_o
);
    localparam int CW = $clog2(DIV + 1);

    logic [CW-1:0] cnt;
    logic          sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt    <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign sclk_o = sclk_q;
    assign fall_o = en && sclk_q && (cnt == CW'(DIV - 1));
endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
    parameter int WORD_W = 16,
    parameter int WORDS  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_en,
    input  logic                    din,
    output logic [WORD_W*WORDS-1:0] q
);
    logic [WORD_W-1:0] word_q [WORDS];
    logic              feed   [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        if (g == WORDS - 1) begin : g_last
            assign feed[g] = din;
        end else begin : g_mid
            assign feed[g] = word_q[g+1][WORD_W-1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else if (shift_en) begin
                word_q[g] <= {word_q[g][WORD_W-2:0], feed[g]};
            end
        end

        assign q[(WORDS-g)*WORD_W-1 -: WORD_W] = word_q[g];
    end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int SCLK_MAX_HZ = 17_000_000,
    parameter int SCLK_DIV    = 2,
    parameter int CNV_LEN     = 3,
    parameter int WORD_W      = 16,
    parameter int WORDS       = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_i,
    input  logic                    busy_i,
    input  logic                    miso_i,
    input  logic                    ovr_clr_i,
    output logic                    cnv_n_o,
    output logic                    cs_n_o,
    output logic                    sclk_o,
    output logic [WORD_W*WORDS-1:0] result_o,
    output logic                    valid_o,
    output logic                    overrun_o
);
    localparam int TOTAL   = WORD_W * WORDS;
    localparam int BCW     = $clog2(TOTAL + 1);
    localparam int GAP_LEN = 2 * SCLK_DIV;
    localparam int TMAX    = (CNV_LEN > GAP_LEN) ? CNV_LEN : GAP_LEN;
    localparam int TW      = $clog2(TMAX + 1);

    rd_state_t      state, nxt;
    logic [TW-1:0]  tcnt;
    logic [BCW-1:0] bcnt;
    logic           ovr_q;
    logic           sclk_en;
    logic           fall;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (tick_i)                         nxt = ST_CONV;
            ST_CONV:    if (tcnt == TW'(CNV_LEN - 1))       nxt = ST_WAIT_HI;
            ST_WAIT_HI: if (busy_i)                         nxt = ST_WAIT_LO;
            ST_WAIT_LO: if (!busy_i)                        nxt = ST_XFER;
            ST_XFER:    if (fall && bcnt == BCW'(TOTAL - 1)) nxt = ST_GAP;
            ST_GAP:     if (tcnt == TW'(GAP_LEN - 1))       nxt = ST_DONE;
            ST_DONE:                                        nxt = ST_IDLE;
            default:                                        nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || nxt != state) tcnt <= '0;
        else                        tcnt <= tcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_XFER) bcnt <= '0;
        else if (fall)                  bcnt <= bcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          ovr_q <= 1'b0;
        else if (tick_i && state != ST_IDLE) ovr_q <= 1'b1;
        else if (ovr_clr_i)                  ovr_q <= 1'b0;
    end

    always_comb begin
        cnv_n_o   = 1'b1;
        cs_n_o    = 1'b1;
        valid_o   = 1'b0;
        sclk_en   = 1'b0;
        unique case (state)
            ST_CONV: cnv_n_o = 1'b0;
            ST_XFER: begin
                cs_n_o  = 1'b0;
                sclk_en = 1'b1;
            end
            ST_DONE: valid_o = 1'b1;
            default: ;
        endcase
    end

    assign overrun_o = ovr_q;

    adc_sclk_gen #(.DIV(SCLK_DIV)) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (sclk_en),
        .sclk_o (sclk_o),
        .fall_o (fall)
    );

    adc_rx_shift #(.WORD_W(WORD_W), .WORDS(WORDS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (fall),
        .din      (miso_i),
        .q        (result_o)
    );
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int SCLK_MAX_HZ = 17_000_000,
    parameter int CNV_LEN     = 3
) (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic busy_i,
    input logic cnv_n_o,
    input logic cs_n_o,
    input logic sclk_o,
    input logic valid_o,
    input logic overrun_o
);
    localparam int MIN_HALF = (CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);

    logic        sclk_q, cnv_q, busy_q, armed;
    logic [15:0] hcnt;
    logic [15:0] clow;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cnv_q  <= 1'b1;
            busy_q <= 1'b0;
            armed  <= 1'b1;
            hcnt   <= 16'hFFFF;
            clow   <= '0;
        end else begin
            sclk_q <= sclk_o;
            cnv_q  <= cnv_n_o;
            busy_q <= busy_i;
            if (sclk_o != sclk_q)     hcnt <= 16'd1;
            else if (hcnt != 16'hFFFF) hcnt <= hcnt + 16'd1;
            if (!cnv_n_o) clow <= clow + 16'd1;
            else          clow <= '0;
            if (cnv_q && !cnv_n_o)      armed <= 1'b0;
            else if (busy_q && !busy_i) armed <= 1'b1;
        end
    end

    // R4
    cpol_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R4
    sclk_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o != sclk_q) |-> (hcnt >= 16'(MIN_HALF)));

    // R2
    no_read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> !busy_i);

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R5
    valid_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> cs_n_o);

    // R6
    ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> $past(tick_i));

    // R1
    cnv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_n_o && !cnv_q) |-> (clow == 16'(CNV_LEN)));

    // R7
    cnv_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_q && !cnv_n_o) |-> armed);
endmodule

bind adc_rd_ctrl adc_rd_chk #(
    .CLK_HZ      (CLK_HZ),
    .SCLK_MAX_HZ (SCLK_MAX_HZ),
    .CNV_LEN     (CNV_LEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .busy_i    (busy_i),
    .cnv_n_o   (cnv_n_o),
    .cs_n_o    (cs_n_o),
    .sclk_o    (sclk_o),
    .valid_o   (valid_o),
    .overrun_o (overrun_o)
);

// File: tb/adc_rd_ctrl_tb.sv
module adc_rd_ctrl_tb;
    localparam int DIV = 2;
    localparam int CNV = 3;

    logic        clk = 1'b0;
    logic        rst_n, tick_i, busy_i, miso_i, ovr_clr_i;
    logic        cnv_n_o, cs_n_o, sclk_o, valid_o, overrun_o;
    logic [31:0] result_o;
    logic [31:0] adc_word;
    logic [5:0]  ridx;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;

    always #10 clk = ~clk;

    adc_rd_ctrl #(.SCLK_DIV(DIV), .CNV_LEN(CNV)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .busy_i(busy_i),
        .miso_i(miso_i), .ovr_clr_i(ovr_clr_i), .cnv_n_o(cnv_n_o),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .result_o(result_o),
        .valid_o(valid_o), .overrun_o(overrun_o)
    );

    // converter model: busy pulse after each convert start
    initial busy_i = 1'b0;
    always begin
        @(negedge cnv_n_o);
        repeat (2) @(negedge clk);
        busy_i = 1'b1;
        repeat (8) @(negedge clk);
        busy_i = 1'b0;
    end

    // converter model: data changes on rising serial clock, MSB first
    initial miso_i = 1'b0;
    always @(posedge sclk_o or posedge cs_n_o) begin
        if (cs_n_o) ridx <= '0;
        else begin
            miso_i <= adc_word[5'd31 - ridx[4:0]];
            ridx   <= ridx + 6'd1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [31:0] w, input bit inject);
        int lowlen = 0, rises = 0, gap = 0, cyc = 0, bad_busy = 0, bad_idle = 0;
        bit psclk = 0, pcs = 1, counting = 0, saw_busy = 0, order_ok = 1, inj = 0;
        adc_word = w;
        @(negedge clk) tick_i = 1'b1;
        forever begin
            @(negedge clk);
            tick_i = 1'b0;
            cyc++;
            if (!cnv_n_o) lowlen++;
            if (busy_i) saw_busy = 1;
            if (!cs_n_o && busy_i) bad_busy++;
            if (cs_n_o && sclk_o) bad_idle++;
            if (!cs_n_o && pcs && !saw_busy) order_ok = 0;
            if (sclk_o && !psclk) rises++;
            if (cs_n_o && !pcs) begin gap = 0; counting = 1; end
            else if (counting) gap++;
            if (inject && rises == 5 && !inj) begin tick_i = 1'b1; inj = 1; end
            psclk = sclk_o;
            pcs   = cs_n_o;
            if (valid_o || cyc > 2000) break;
        end
        chk(valid_o, "R5 valid seen", {31'd0, valid_o}, 32'd1);
        chk(result_o == w, "R3 result", result_o, w);
        chk(rises == 32, "R3 sclk rises", rises, 32);
        chk(lowlen == CNV, "R1/R7 cnv low length", lowlen, CNV);
        chk(gap == 2 * DIV, "R5 cs-to-valid gap", gap, 2 * DIV);
        chk(order_ok && bad_busy == 0, "R2 read after busy", bad_busy, 0);
        chk(bad_idle == 0, "R4 sclk idle low", bad_idle, 0);
        @(negedge clk);
        chk(!valid_o, "R5 valid one cycle", {31'd0, valid_o}, 32'd0);
        repeat (12) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; tick_i = 1'b0; ovr_clr_i = 1'b0; adc_word = '0;
        repeat (3) @(negedge clk);
        chk(cnv_n_o && cs_n_o, "R8 selects high", {30'd0, cnv_n_o, cs_n_o}, 32'd3);
        chk(!sclk_o && !valid_o && !overrun_o, "R8 outputs low",
            {29'd0, sclk_o, valid_o, overrun_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_frame(32'h0000_0000, 0);
        run_frame(32'hFFFF_FFFF, 0);
        run_frame(32'h1234_ABCD, 0);
        for (int i = 0; i < 32; i++) begin
            run_frame(32'd1 << i, 0);
            run_frame(~(32'd1 << i), 0);
        end
        chk(!overrun_o, "R6 no overrun in clean frames", {31'd0, overrun_o}, 32'd0);

        // tick during readout: dropped, frame intact, flag set
        run_frame(32'hA5C3_5A3C, 1);
        chk(overrun_o, "R6 overrun set", {31'd0, overrun_o}, 32'd1);
        chk(cnv_n_o && cs_n_o, "R6 dropped tick starts nothing", {30'd0, cnv_n_o, cs_n_o}, 32'd3);
        @(negedge clk) ovr_clr_i = 1'b1;
        @(negedge clk) ovr_clr_i = 1'b0;
        chk(!overrun_o, "R6 overrun cleared", {31'd0, overrun_o}, 32'd0);
        run_frame(32'h0F0F_F0F0, 0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule